// File: doc/BRIEF.md
# Floating-Point Compare Condition Unit

This block compares two IEEE floating-point operands, either both single precision (32-bit) or both double precision (64-bit). It classifies the pair as equal, less, greater or unordered and writes the 2-bit result into one of four condition fields of a 32-bit status word. The caller presents the current status word together with the operands. One cycle later the block returns the updated word. Only the chosen field differs from the word that was presented.

A NaN in either operand gives the unordered code. If the status word has its invalid-operation trap enable set, an unordered result also raises a trap request. A small decoder, which is purely combinational, turns the 2-bit rounding-direction field of the incoming status word into a one-hot rounding-mode code for the arithmetic units nearby.

Top module: `fcmp_cond_unit`

## Requirements
- R1: Condition field k (k = 0..3, chosen by `fld_sel`) occupies status bits [2k+1:2k]. Only that field is replaced. Every other bit of `stat_out` equals the `stat_in` that was presented with the strobe.
- R2: The result codes are equal = 2'b00, less (a < b) = 2'b01, greater (a > b) = 2'b10 and unordered = 2'b11.
- R3: An operand is a NaN only when its exponent is all ones and its fraction is nonzero. Infinities are ordered: -inf is below every finite value and +inf is above every finite value.
- R4: +0 and -0 compare as equal. Ordered nonzero operands are ordered by their numeric value, including negative values.
- R5: With `is_dbl` = 0 only bits [31:0] of each operand are used (sign bit 31, exponent 30:23, fraction 22:0), and bits [63:32] have no effect. With `is_dbl` = 1 the full 64 bits are used (sign bit 63, exponent 62:52, fraction 51:0).
- R6: `trap_req` pulses together with `done` exactly when the result is unordered and status bit 8 (invalid-operation trap enable) was set in `stat_in`. Otherwise it stays 0.
- R7: `done` is a one-cycle pulse in the cycle after `cmp_valid`. `stat_out` takes its new value in that same cycle and keeps it while no strobe arrives.
- R8: `rnd_mode` decodes status bits [10:9] of `stat_in` combinationally: 00 gives 4'b0001 (nearest-even), 01 gives 4'b0010 (toward zero), 10 gives 4'b0100 (toward +inf) and 11 gives 4'b1000 (toward -inf).
- R9: While `rst_n` is low at a clock edge, `stat_out`, `done` and `trap_req` are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_valid | input | 1 | Compare strobe |
| op_a | input | 64 | First operand (single in bits 31:0) |
| op_b | input | 64 | Second operand (single in bits 31:0) |
| is_dbl | input | 1 | 1 = double precision, 0 = single |
| fld_sel | input | 2 | Condition field to update |
| stat_in | input | 32 | Current status word |
| stat_out | output | 32 | Updated status word |
| done | output | 1 | Result valid pulse |
| trap_req | output | 1 | Floating-point exception trap request |
| rnd_mode | output | 4 | One-hot rounding mode decoded from stat_in |

## Verification
The rounding decoder and the compare both read `stat_in` in the same cycle. A strobe therefore always meets some rounding-direction value. The bench randomizes those bits on every compare and checks `rnd_mode` while the strobe is held. One cycle later it checks that the rounding bits passed into `stat_out` unchanged. The trap request and the field write also land in the same cycle. NaN operands are paired with random trap-enable values, and `trap_req` is judged against the field that was written in that cycle.

// File: rtl/fcmp_pkg.sv
// Shared types for the floating-point compare unit.
// Assumes operand buses are at most 64 bits wide.
package fcmp_pkg;

    localparam int OPW = 64;

    // Two-bit condition result written into a status field.
    typedef enum logic [1:0] {
        CC_EQ = 2'b00,
        CC_LT = 2'b01,
        CC_GT = 2'b10,
        CC_UN = 2'b11
    } cc_e;

    // One-hot rounding mode code.
    typedef enum logic [3:0] {
        RM_NEAREST = 4'b0001,
        RM_ZERO    = 4'b0010,
        RM_UP      = 4'b0100,
        RM_DOWN    = 4'b1000
    } rmode_e;

    // Operand after unpacking, independent of precision.
    typedef struct packed {
        logic           sign;
        logic           is_nan;
        logic           is_zero;
        logic [OPW-2:0] mag;
    } fp_unpk_t;

endpackage

// File: rtl/fcmp_unpack.sv
// Unpacks one operand into sign, NaN flag, zero flag and magnitude.
// Single precision reads only the low 32 bits; the magnitude is zero-extended
// so that one unsigned compare works for both precisions.
module fcmp_unpack
    import fcmp_pkg::*;
#(
    parameter int SP_EXP  = 8,
    parameter int SP_FRAC = 23,
    parameter int DP_EXP  = 11,
    parameter int DP_FRAC = 52
) (
    input  logic [OPW-1:0] op,
    input  logic           is_dbl,
    output fp_unpk_t       unpk
);
    localparam int SPW = 1 + SP_EXP + SP_FRAC;
    localparam int DPW = 1 + DP_EXP + DP_FRAC;

    logic sp_nan, dp_nan;

    // Detect NaN per format: exponent all ones and fraction nonzero.
    always_comb begin
        sp_nan = (&op[SPW-2:SP_FRAC]) && (|op[SP_FRAC-1:0]);
        dp_nan = (&op[DPW-2:DP_FRAC]) && (|op[DP_FRAC-1:0]);
    end

    // Select the fields of the active precision.
    always_comb begin
        if (is_dbl) begin
            unpk.sign   = op[DPW-1];
            unpk.is_nan = dp_nan;
            unpk.mag    = OPW'(op[DPW-2:0]);
        end else begin
            unpk.sign   = op[SPW-1];
            unpk.is_nan = sp_nan;
            unpk.mag    = (OPW-1)'(op[SPW-2:0]);
        end
        unpk.is_zero = (unpk.mag == '0);
    end
endmodule

// File: rtl/fcmp_order.sv
// Classifies two unpacked operands as equal, less, greater or unordered.
// Assumes magnitudes are in sign-magnitude IEEE order (bigger bits = bigger value).
module fcmp_order
    import fcmp_pkg::*;
(
    input  fp_unpk_t a,
    input  fp_unpk_t b,
    output cc_e      cc
);
    logic a_mag_gt;
    logic mag_eq;

    // Magnitude relations shared by both sign cases.
    always_comb begin
        a_mag_gt = (a.mag > b.mag);
        mag_eq   = (a.mag == b.mag);
    end

    // Priority: NaN, both zeros, differing signs, then magnitude.
    always_comb begin
        if (a.is_nan || b.is_nan)
            cc = CC_UN;
        else if (a.is_zero && b.is_zero)
            cc = CC_EQ;
        else if (a.sign != b.sign)
            cc = a.sign ? CC_LT : CC_GT;
        else if (mag_eq)
            cc = CC_EQ;
        else if (a.sign)
            cc = a_mag_gt ? CC_LT : CC_GT;
        else
            cc = a_mag_gt ? CC_GT : CC_LT;
    end
endmodule

// File: rtl/fcmp_round_decode.sv
// Maps the 2-bit rounding-direction field to a one-hot rounding mode.
// Purely combinational; assumes the caller extracts the field.
module fcmp_round_decode
    import fcmp_pkg::*;
(
    input  logic [1:0] rnd_fld,
    output rmode_e     mode
);
    // Field value to mode lookup.
    always_comb begin
        unique case (rnd_fld)
            2'b00:   mode = RM_NEAREST;
            2'b01:   mode = RM_ZERO;
            2'b10:   mode = RM_UP;
            default: mode = RM_DOWN;
        endcase
    end

    assert_rmode_onehot_R8: assert final ($countones(mode) == 1);
endmodule

// File: rtl/fcmp_cond_unit.sv
// Floating-point compare condition unit.
// Compares two operands and returns a copy of the status word in which the
// selected 2-bit condition field holds the result, one cycle after the strobe.
// It also raises a trap for an unordered result when trapping is enabled, and
// decodes the rounding-direction field. Assumes a synchronous active-low reset.
module fcmp_cond_unit
    import fcmp_pkg::*;
#(
    parameter int SW          = 32,
    parameter int NFIELD      = 4,
    parameter int CC_LSB      = 0,
    parameter int TRAP_EN_BIT = 8,
    parameter int RND_LSB     = 9
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cmp_valid,
    input  logic [OPW-1:0]            op_a,
    input  logic [OPW-1:0]            op_b,
    input  logic                      is_dbl,
    input  logic [$clog2(NFIELD)-1:0] fld_sel,
    input  logic [SW-1:0]             stat_in,
    output logic [SW-1:0]             stat_out,
    output logic                      done,
    output logic                      trap_req,
    output logic [3:0]                rnd_mode
);
    localparam int SELW = $clog2(NFIELD);

    fp_unpk_t             unpk [2];
    logic [OPW-1:0]       ops  [2];
    cc_e                  cc;
    rmode_e               rmode;
    logic [SW-1:0]        stat_nxt;
    logic [SW-1:0]        stat_q;
    logic                 done_q;
    logic                 trap_q;
    logic [SELW-1:0]      sel_q;

    assign ops[0] = op_a;
    assign ops[1] = op_b;

    // One unpacker per operand.
    for (genvar g = 0; g < 2; g++) begin : g_unpk
        fcmp_unpack u_unpack (
            .op     (ops[g]),
            .is_dbl (is_dbl),
            .unpk   (unpk[g])
        );
    end

    fcmp_order u_order (
        .a  (unpk[0]),
        .b  (unpk[1]),
        .cc (cc)
    );

    fcmp_round_decode u_rnd (
        .rnd_fld (stat_in[RND_LSB +: 2]),
        .mode    (rmode)
    );
    assign rnd_mode = rmode;

    // Clear the selected field and insert the new result.
    always_comb begin
        stat_nxt = stat_in;
        stat_nxt[CC_LSB + 2*fld_sel +: 2] = cc;
    end

    // Register the result, the done pulse and the trap request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
            done_q <= 1'b0;
            trap_q <= 1'b0;
            sel_q  <= '0;
        end else begin
            done_q <= cmp_valid;
            trap_q <= cmp_valid && (cc == CC_UN) && stat_in[TRAP_EN_BIT];
            if (cmp_valid) begin
                stat_q <= stat_nxt;
                sel_q  <= fld_sel;
            end
        end
    end

    assign stat_out = stat_q;
    assign done     = done_q;
    assign trap_req = trap_q;

    // Mask that covers one condition field.
    function automatic logic [SW-1:0] fld_mask(input logic [SELW-1:0] s);
        fld_mask = '0;
        fld_mask[CC_LSB + 2*s +: 2] = 2'b11;
    endfunction

    assert_done_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid |=> done);
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_valid |=> !done && $stable(stat_out));
    assert_other_bits_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid |=> (((stat_out ^ $past(stat_in)) & ~fld_mask($past(fld_sel))) == '0));
    assert_trap_unordered_R6: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> done && (stat_out[CC_LSB + 2*sel_q +: 2] == 2'b11)
                     && stat_out[TRAP_EN_BIT]);
    assert_nan_unordered_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && (unpk[0].is_nan || unpk[1].is_nan)) |=>
            (stat_out[CC_LSB + 2*sel_q +: 2] == 2'b11));
endmodule

// File: tb/test_fcmp_cond_unit.sv
module test_fcmp_cond_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmp_valid;
    logic [63:0] op_a, op_b;
    logic        is_dbl;
    logic [1:0]  fld_sel;
    logic [31:0] stat_in;
    logic [31:0] stat_out;
    logic        done, trap_req;
    logic [3:0]  rnd_mode;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fcmp_cond_unit i_fcmp_cond_unit (
        .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .op_a(op_a), .op_b(op_b),
        .is_dbl(is_dbl), .fld_sel(fld_sel), .stat_in(stat_in), .stat_out(stat_out),
        .done(done), .trap_req(trap_req), .rnd_mode(rnd_mode)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference: NaN test per format, then order through a signed integer key.
    function automatic logic [1:0] ref_cc(input logic [63:0] a, input logic [63:0] b, input bit dbl);
        longint ka, kb;
        bit na, nb;
        if (dbl) begin
            na = (a[62:52] == 11'h7FF) && (a[51:0] != 0);
            nb = (b[62:52] == 11'h7FF) && (b[51:0] != 0);
            ka = a[63] ? -longint'({1'b0, a[62:0]}) : longint'({1'b0, a[62:0]});
            kb = b[63] ? -longint'({1'b0, b[62:0]}) : longint'({1'b0, b[62:0]});
        end else begin
            na = (a[30:23] == 8'hFF) && (a[22:0] != 0);
            nb = (b[30:23] == 8'hFF) && (b[22:0] != 0);
            ka = a[31] ? -longint'(a[30:0]) : longint'(a[30:0]);
            kb = b[31] ? -longint'(b[30:0]) : longint'(b[30:0]);
        end
        if (na || nb) return 2'b11;
        if (ka < kb)  return 2'b01;
        if (ka > kb)  return 2'b10;
        return 2'b00;
    endfunction

    function automatic logic [3:0] ref_rm(input logic [1:0] f);
        return 4'b0001 << f;
    endfunction

    // One compare: drive at negedge, check the strobe-cycle decode, then the result.
    task automatic do_cmp(input logic [63:0] a, input logic [63:0] b, input bit dbl,
                          input logic [1:0] sel, input logic [31:0] st);
        logic [31:0] exp_st;
        logic [1:0]  c;
        @(negedge clk);
        op_a = a; op_b = b; is_dbl = dbl; fld_sel = sel; stat_in = st; cmp_valid = 1'b1;
        #1;
        check("R8 rnd_mode during strobe", 64'(rnd_mode), 64'(ref_rm(st[10:9])));
        c = ref_cc(a, b, dbl);
        exp_st = st;
        exp_st[2*sel +: 2] = c;
        @(negedge clk);
        cmp_valid = 1'b0;
        op_a = $urandom(); op_b = {$urandom(), $urandom()}; stat_in = $urandom();
        check("R7 done", 64'(done), 64'd1);
        check("R1 R2 stat_out", 64'(stat_out), 64'(exp_st));
        check("R6 trap_req", 64'(trap_req), 64'(c == 2'b11 && st[8]));
    endtask

    function automatic logic [63:0] special(input bit dbl, input int k);
        case (k)
            0: return dbl ? 64'h0 : 64'h0;
            1: return dbl ? 64'h8000_0000_0000_0000 : 64'h8000_0000;
            2: return dbl ? 64'h7FF0_0000_0000_0000 : 64'h7F80_0000;
            3: return dbl ? 64'hFFF0_0000_0000_0000 : 64'hFF80_0000;
            4: return dbl ? 64'h7FF8_0000_0000_0000 : 64'h7FC0_0000;
            5: return dbl ? 64'hFFF0_0000_0000_0001 : 64'hFF80_0001;
            6: return dbl ? 64'h3FF0_0000_0000_0000 : 64'h3F80_0000;
            default: return dbl ? 64'hBFF0_0000_0000_0000 : 64'hBF80_0000;
        endcase
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; cmp_valid = 1'b0; op_a = '0; op_b = '0; is_dbl = 1'b0;
        fld_sel = '0; stat_in = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        check("R9 stat_out reset", 64'(stat_out), 64'd0);
        check("R9 done reset", 64'(done), 64'd0);
        check("R9 trap reset", 64'(trap_req), 64'd0);
        rst_n = 1'b1;

        // R8: every rounding field value, no strobe.
        for (int f = 0; f < 4; f++) begin
            @(negedge clk);
            stat_in = 32'(f) << 9;
            #1;
            check("R8 rnd_mode decode", 64'(rnd_mode), 64'(ref_rm(2'(f))));
        end

        // R4: +0 vs -0 equal, both precisions, all fields.
        for (int s = 0; s < 4; s++) begin
            do_cmp(special(0, 0), special(0, 1), 0, 2'(s), 32'hFFFF_FFFF);
            do_cmp(special(1, 1), special(1, 0), 1, 2'(s), 32'h0000_0000);
        end
        // R3: infinities ordered, NaN unordered with and without trap enable (R6).
        do_cmp(special(0, 3), special(0, 7), 0, 2'd1, 32'h0);
        do_cmp(special(1, 2), special(1, 6), 1, 2'd2, 32'h0);
        do_cmp(special(0, 4), special(0, 6), 0, 2'd3, 32'h0000_0100);
        do_cmp(special(1, 6), special(1, 5), 1, 2'd0, 32'h0000_0000);
        do_cmp(special(1, 5), special(1, 5), 1, 2'd0, 32'h0000_0100);
        // R4: negative ordering, R2 less.
        do_cmp(64'hC000_0000, 64'hBF80_0000, 0, 2'd2, 32'h1234_5678);
        // R5: upper bits are a NaN pattern but single mode ignores them.
        do_cmp(64'h7FF8_0000_3F80_0000, 64'h7FF8_0000_3F80_0000, 0, 2'd1, 32'h0000_0100);
        // R5: low bits differ but double upper bits decide.
        do_cmp(64'h3FF0_0000_FFFF_FFFF, 64'h4000_0000_0000_0000, 1, 2'd3, 32'h0);

        // R7: idle cycle after a result, done drops and stat_out holds.
        begin
            logic [31:0] held;
            held = stat_out;
            @(negedge clk);
            check("R7 done pulse drops", 64'(done), 64'd0);
            check("R7 stat_out holds", 64'(stat_out), 64'(held));
        end

        // Random mix: random bits, specials, equal and sign-flipped pairs.
        for (int n = 0; n < 3000; n++) begin
            bit dbl;
            logic [63:0] a, b;
            int m;
            dbl = $urandom_range(0, 1);
            a = {$urandom(), $urandom()};
            m = $urandom_range(0, 4);
            case (m)
                0: b = {$urandom(), $urandom()};
                1: b = a;
                2: b = dbl ? (a ^ 64'h8000_0000_0000_0000) : (a ^ 64'h8000_0000);
                3: begin a = special(dbl, $urandom_range(0, 7)); b = special(dbl, $urandom_range(0, 7)); end
                default: begin a = special(dbl, $urandom_range(0, 7)); b = {$urandom(), $urandom()}; end
            endcase
            do_cmp(a, b, dbl, 2'($urandom_range(0, 3)), $urandom());
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule